// File: doc/BRIEF.md
# Instruction Next-Block Prefetch Burst Generator

This block sits next to a cache and sees at most one demand access per cycle: an address, a flag telling whether the access is an instruction fetch, and the ID of the requesting context. When instruction tagging is switched on and the access is an instruction fetch, the block skips stride prediction. It produces a short burst of prefetch candidates instead. Candidate number d is the trigger address plus d whole cache blocks, for d from 1 up to a configured degree. If page stopping is on, the burst ends at the first candidate that falls in a different page from the trigger. The candidates that are dropped this way are added to a statistics counter.

Each candidate leaves on a valid/ready port, one per cycle, with the configured latency value beside it. All other accesses go out on a bypass port, one cycle after they are accepted, for a separate stride-prediction path. This includes data accesses and instruction fetches made while tagging is off. An access with a context ID at or above the configured context count raises an error pulse and is dropped. Three configuration registers are loaded through a single write strobe: the tagging enable, the page-stop enable and the latency tag. Both enables come out of reset set.

Top module: `ifetch_burst_prefetcher`

## Requirements
- R1: After reset, pfValid, strideValid and ctxError are 0. accReady is 1. spanCount and issueCount are 0. Tagging and page stopping are both enabled, and the latency tag equals LAT_RST.
- R2: An accepted instruction fetch with a valid context and tagging enabled starts a burst. pfValid rises in the cycle after acceptance. Candidate d (1..DEGREE) is the trigger address plus d·BLK_BYTES, and candidates are offered in increasing d. The next candidate is offered after each cycle with pfValid and pfReady both high.
- R3: With page stopping enabled, the first candidate whose address bits above log2(PAGE_BYTES) differ from those of the trigger is never offered. No later candidate of that burst is offered either, and the block returns to idle.
- R4: When a burst is cut at candidate d, spanCount increases by DEGREE−d+1.
- R5: pfLatency equals the configured latency tag whenever pfValid is high.
- R6: With page stopping disabled, all DEGREE candidates are offered, even across a page boundary, and spanCount does not change.
- R7: An accepted access that does not start a burst, and has a valid context, pulses strideValid for one cycle, in the cycle after acceptance. The pulse carries the access's address, context and instruction flag. An access that starts a burst is never forwarded.
- R8: An accepted access whose context ID is at or above MAX_CTX pulses ctxError for one cycle, in the cycle after acceptance. It starts no burst and is not forwarded.
- R9: accReady is 0 while a burst is active, and an access offered then is not taken. While pfValid is high and pfReady is low, pfValid stays high and pfAddr holds its value.
- R10: issueCount increases by one for each cycle in which pfValid and pfReady are both high.
- R11: A cycle with cfgWe high loads the tagging enable, the page-stop enable and the latency tag from cfgInstTagged, cfgPageStop and cfgLatency. The new values apply to accesses accepted afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWe | input | 1 | Configuration write strobe |
| cfgInstTagged | input | 1 | New tagging enable |
| cfgPageStop | input | 1 | New page-stop enable |
| cfgLatency | input | LAT_W | New latency tag |
| accValid | input | 1 | Demand access present |
| accReady | output | 1 | Block is idle and takes an access |
| accAddr | input | ADDR_W | Demand access byte address |
| accIsInst | input | 1 | Access is an instruction fetch |
| accCtx | input | CTX_W | Requester context ID |
| pfValid | output | 1 | Prefetch candidate present |
| pfReady | input | 1 | Candidate taken by the consumer |
| pfAddr | output | ADDR_W | Candidate address |
| pfLatency | output | LAT_W | Latency tag paired with the candidate |
| strideValid | output | 1 | Bypass access pulse to the stride path |
| strideAddr | output | ADDR_W | Forwarded address |
| strideCtx | output | CTX_W | Forwarded context ID |
| strideIsInst | output | 1 | Forwarded instruction flag |
| ctxError | output | 1 | Context ID out of range pulse |
| spanCount | output | CNT_W | Running count of candidates dropped at page boundaries |
| issueCount | output | CNT_W | Running count of candidates handed over |

## Verification
An access is taken on the clock edge where accValid and accReady are both high. Its results then appear one edge later: the first candidate, the stride pulse, or the error pulse. Each later candidate follows one edge after the previous handshake. A cut burst returns accReady high one edge after the cycle in which it stops, and the span counter changes on that same edge. Inputs are driven and outputs are sampled on the falling clock edge. Every check therefore sees the state settled after the preceding rising edge: the pulse checks are made on the first falling edge after acceptance, and the candidate checks on each falling edge until accReady returns.

// File: rtl/ipf_pkg.sv
package ipf_pkg;

  // Strobes from the burst controller to the datapath
  typedef struct packed {
    logic loadBase;   // capture trigger address, first candidate
    logic advance;    // step candidate by one block
    logic cutBurst;   // burst ended at a page boundary
    logic issue;      // candidate handed over this cycle
    logic fwdStride;  // forward access to the stride path
  } ipf_strobe_t;

endpackage

// File: rtl/ipf_cfg_regs.sv
module ipf_cfg_regs #(
  parameter int LAT_W   = 8,
  parameter int LAT_RST = 12
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgWe,
  input  logic             cfgInstTagged,
  input  logic             cfgPageStop,
  input  logic [LAT_W-1:0] cfgLatency,
  output logic             instTaggedQ,
  output logic             pageStopQ,
  output logic [LAT_W-1:0] latencyQ
);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      instTaggedQ <= 1'b1;
      pageStopQ   <= 1'b1;
      latencyQ    <= LAT_W'(LAT_RST);
    end else if (cfgWe) begin
      instTaggedQ <= cfgInstTagged;
      pageStopQ   <= cfgPageStop;
      latencyQ    <= cfgLatency;
    end
  end

endmodule

// File: rtl/ipf_ctrl.sv
module ipf_ctrl
  import ipf_pkg::*;
#(
  parameter int DEGREE  = 4,
  parameter int MAX_CTX = 6,
  parameter int CTX_W   = 3,
  localparam int RW     = $clog2(DEGREE + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             accValid,
  input  logic             accIsInst,
  input  logic [CTX_W-1:0] accCtx,
  input  logic             instTagged,
  input  logic             pageStop,
  input  logic             crossing,
  input  logic             pfReady,
  output logic             accReady,
  output logic             pfValid,
  output logic             ctxError,
  output logic [RW-1:0]    remain,
  output ipf_strobe_t      strobe
);

  typedef enum logic {ST_IDLE, ST_BURST} state_t;

  state_t  stateQ, stateD;
  logic [RW-1:0] remainQ, remainD;
  logic    accept, ctxBad, startBurst, lastIssue;

  assign accReady   = (stateQ == ST_IDLE);
  assign accept     = accValid && accReady;
  assign ctxBad     = ({1'b0, accCtx} >= (CTX_W+1)'(MAX_CTX));
  assign startBurst = accept && !ctxBad && accIsInst && instTagged;

  always_comb begin
    strobe           = '0;
    pfValid          = 1'b0;
    stateD           = stateQ;
    remainD          = remainQ;
    lastIssue        = 1'b0;
    strobe.loadBase  = startBurst;
    strobe.fwdStride = accept && !ctxBad && !startBurst;
    if (startBurst) begin
      stateD  = ST_BURST;
      remainD = RW'(DEGREE);
    end
    if (stateQ == ST_BURST) begin
      if (pageStop && crossing) begin
        strobe.cutBurst = 1'b1;
        stateD          = ST_IDLE;
      end else begin
        pfValid = 1'b1;
        if (pfReady) begin
          strobe.issue   = 1'b1;
          strobe.advance = 1'b1;
          lastIssue      = (remainQ == RW'(1));
          remainD        = remainQ - RW'(1);
          if (lastIssue) stateD = ST_IDLE;
        end
      end
    end
  end

  assign remain = remainQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ   <= ST_IDLE;
      remainQ  <= '0;
      ctxError <= 1'b0;
    end else begin
      stateQ   <= stateD;
      remainQ  <= remainD;
      ctxError <= accept && ctxBad;
    end
  end

endmodule

// File: rtl/ipf_datapath.sv
module ipf_datapath
  import ipf_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int BLK_BYTES  = 64,
  parameter int PAGE_BYTES = 4096,
  parameter int DEGREE     = 4,
  parameter int CTX_W      = 3,
  parameter int CNT_W      = 16,
  localparam int RW        = $clog2(DEGREE + 1),
  localparam int PG_SH     = $clog2(PAGE_BYTES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  ipf_strobe_t       strobe,
  input  logic [RW-1:0]     remain,
  input  logic [ADDR_W-1:0] accAddr,
  input  logic              accIsInst,
  input  logic [CTX_W-1:0]  accCtx,
  output logic              crossing,
  output logic [ADDR_W-1:0] pfAddr,
  output logic              strideValid,
  output logic [ADDR_W-1:0] strideAddr,
  output logic [CTX_W-1:0]  strideCtx,
  output logic              strideIsInst,
  output logic [CNT_W-1:0]  spanCount,
  output logic [CNT_W-1:0]  issueCount
);

  localparam logic [ADDR_W-1:0] BLK_STEP = ADDR_W'(BLK_BYTES);

  logic [ADDR_W-1:0] baseQ, candQ;

  assign crossing = (candQ[ADDR_W-1:PG_SH] != baseQ[ADDR_W-1:PG_SH]);
  assign pfAddr   = candQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      baseQ <= '0;
      candQ <= '0;
    end else if (strobe.loadBase) begin
      baseQ <= accAddr;
      candQ <= accAddr + BLK_STEP;
    end else if (strobe.advance) begin
      candQ <= candQ + BLK_STEP;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      spanCount  <= '0;
      issueCount <= '0;
    end else begin
      if (strobe.cutBurst) spanCount  <= spanCount + CNT_W'(remain);
      if (strobe.issue)    issueCount <= issueCount + CNT_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      strideValid  <= 1'b0;
      strideAddr   <= '0;
      strideCtx    <= '0;
      strideIsInst <= 1'b0;
    end else begin
      strideValid <= strobe.fwdStride;
      if (strobe.fwdStride) begin
        strideAddr   <= accAddr;
        strideCtx    <= accCtx;
        strideIsInst <= accIsInst;
      end
    end
  end

endmodule

// File: rtl/ifetch_burst_prefetcher.sv
module ifetch_burst_prefetcher
  import ipf_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int BLK_BYTES  = 64,
  parameter int PAGE_BYTES = 4096,
  parameter int DEGREE     = 4,
  parameter int MAX_CTX    = 6,
  parameter int CTX_W      = 3,
  parameter int LAT_W      = 8,
  parameter int LAT_RST    = 12,
  parameter int CNT_W      = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWe,
  input  logic              cfgInstTagged,
  input  logic              cfgPageStop,
  input  logic [LAT_W-1:0]  cfgLatency,
  input  logic              accValid,
  output logic              accReady,
  input  logic [ADDR_W-1:0] accAddr,
  input  logic              accIsInst,
  input  logic [CTX_W-1:0]  accCtx,
  output logic              pfValid,
  input  logic              pfReady,
  output logic [ADDR_W-1:0] pfAddr,
  output logic [LAT_W-1:0]  pfLatency,
  output logic              strideValid,
  output logic [ADDR_W-1:0] strideAddr,
  output logic [CTX_W-1:0]  strideCtx,
  output logic              strideIsInst,
  output logic              ctxError,
  output logic [CNT_W-1:0]  spanCount,
  output logic [CNT_W-1:0]  issueCount
);

  localparam int RW = $clog2(DEGREE + 1);

  ipf_strobe_t   strobe;
  logic [RW-1:0] remain;
  logic          crossing, instTaggedQ, pageStopQ;

  ipf_cfg_regs #(.LAT_W(LAT_W), .LAT_RST(LAT_RST)) u_cfg (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgInstTagged(cfgInstTagged),
    .cfgPageStop(cfgPageStop), .cfgLatency(cfgLatency),
    .instTaggedQ(instTaggedQ), .pageStopQ(pageStopQ), .latencyQ(pfLatency)
  );

  ipf_ctrl #(.DEGREE(DEGREE), .MAX_CTX(MAX_CTX), .CTX_W(CTX_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .accValid(accValid), .accIsInst(accIsInst),
    .accCtx(accCtx), .instTagged(instTaggedQ), .pageStop(pageStopQ),
    .crossing(crossing), .pfReady(pfReady), .accReady(accReady),
    .pfValid(pfValid), .ctxError(ctxError), .remain(remain), .strobe(strobe)
  );

  ipf_datapath #(
    .ADDR_W(ADDR_W), .BLK_BYTES(BLK_BYTES), .PAGE_BYTES(PAGE_BYTES),
    .DEGREE(DEGREE), .CTX_W(CTX_W), .CNT_W(CNT_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .remain(remain),
    .accAddr(accAddr), .accIsInst(accIsInst), .accCtx(accCtx),
    .crossing(crossing), .pfAddr(pfAddr), .strideValid(strideValid),
    .strideAddr(strideAddr), .strideCtx(strideCtx), .strideIsInst(strideIsInst),
    .spanCount(spanCount), .issueCount(issueCount)
  );

endmodule

// File: rtl/ifetch_burst_prefetcher_chk.sv
module ifetch_burst_prefetcher_chk #(
  parameter int ADDR_W  = 32,
  parameter int MAX_CTX = 6,
  parameter int CTX_W   = 3,
  parameter int CNT_W   = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              accValid,
  input logic              accReady,
  input logic [CTX_W-1:0]  accCtx,
  input logic              pfValid,
  input logic              pfReady,
  input logic [ADDR_W-1:0] pfAddr,
  input logic              strideValid,
  input logic              ctxError,
  input logic [CNT_W-1:0]  spanCount,
  input logic [CNT_W-1:0]  issueCount
);

  a_r9_busy_not_ready: assert property (@(posedge clk) disable iff (!rstN)
    pfValid |-> !accReady);

  a_r9_hold_on_stall: assert property (@(posedge clk) disable iff (!rstN)
    (pfValid && !pfReady) |=> (pfValid && $stable(pfAddr)));

  a_r10_issue_count: assert property (@(posedge clk) disable iff (!rstN)
    (pfValid && pfReady) |=> (issueCount == $past(issueCount) + CNT_W'(1)));

  a_r7_stride_after_accept: assert property (@(posedge clk) disable iff (!rstN)
    strideValid |-> $past(accValid && accReady));

  a_r8_err_after_bad_ctx: assert property (@(posedge clk) disable iff (!rstN)
    ctxError |-> $past(accValid && accReady && ({1'b0, accCtx} >= (CTX_W+1)'(MAX_CTX))));

  a_r8_err_excludes_stride: assert property (@(posedge clk) disable iff (!rstN)
    !(ctxError && strideValid));

  a_r4_span_only_on_cut: assert property (@(posedge clk) disable iff (!rstN)
    (spanCount != $past(spanCount)) |-> $past(!pfValid && !accReady));

endmodule

bind ifetch_burst_prefetcher ifetch_burst_prefetcher_chk #(
  .ADDR_W(ADDR_W), .MAX_CTX(MAX_CTX), .CTX_W(CTX_W), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rstN(rstN), .accValid(accValid), .accReady(accReady),
  .accCtx(accCtx), .pfValid(pfValid), .pfReady(pfReady), .pfAddr(pfAddr),
  .strideValid(strideValid), .ctxError(ctxError), .spanCount(spanCount),
  .issueCount(issueCount)
);

// File: tb/ifetch_burst_prefetcher_tb.sv
module ifetch_burst_prefetcher_tb;

  localparam int AW = 32, BLK = 64, PAGE = 4096, DEG = 4, MAXC = 6;
  localparam int CW = 3, LW = 8, LRST = 12, CNTW = 16;

  typedef struct packed {
    logic [31:0] addr;
    logic        isInst;
    logic [2:0]  ctx;
    logic [2:0]  expIssued;
    logic        expStride;
    logic        expErr;
  } vec_t;

  localparam vec_t VEC [7] = '{
    '{addr: 32'h0000_1000, isInst: 1'b1, ctx: 3'd0, expIssued: 3'd4, expStride: 1'b0, expErr: 1'b0},
    '{addr: 32'h0000_1F40, isInst: 1'b1, ctx: 3'd2, expIssued: 3'd2, expStride: 1'b0, expErr: 1'b0},
    '{addr: 32'h0000_1FC0, isInst: 1'b1, ctx: 3'd1, expIssued: 3'd0, expStride: 1'b0, expErr: 1'b0},
    '{addr: 32'h0000_2345, isInst: 1'b0, ctx: 3'd1, expIssued: 3'd0, expStride: 1'b1, expErr: 1'b0},
    '{addr: 32'h0000_3F00, isInst: 1'b1, ctx: 3'd5, expIssued: 3'd3, expStride: 1'b0, expErr: 1'b0},
    '{addr: 32'h0000_4000, isInst: 1'b1, ctx: 3'd6, expIssued: 3'd0, expStride: 1'b0, expErr: 1'b1},
    '{addr: 32'h0000_5010, isInst: 1'b0, ctx: 3'd7, expIssued: 3'd0, expStride: 1'b0, expErr: 1'b1}
  };

  logic clk = 1'b0, rstN = 1'b0;
  logic cfgWe = 1'b0, cfgInstTagged = 1'b1, cfgPageStop = 1'b1;
  logic [LW-1:0] cfgLatency = '0;
  logic accValid = 1'b0, accIsInst = 1'b0, pfReady = 1'b1;
  logic [AW-1:0] accAddr = '0;
  logic [CW-1:0] accCtx = '0;
  logic accReady, pfValid, strideValid, strideIsInst, ctxError;
  logic [AW-1:0] pfAddr, strideAddr;
  logic [LW-1:0] pfLatency;
  logic [CW-1:0] strideCtx;
  logic [CNTW-1:0] spanCount, issueCount;

  int checks = 0, fails = 0;
  int expIssueTotal = 0;
  int expSpan = 0;
  int curLat = LRST;
  bit curStop = 1'b1;

  always #10 clk = ~clk;

  ifetch_burst_prefetcher u_dut (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgInstTagged(cfgInstTagged),
    .cfgPageStop(cfgPageStop), .cfgLatency(cfgLatency), .accValid(accValid),
    .accReady(accReady), .accAddr(accAddr), .accIsInst(accIsInst),
    .accCtx(accCtx), .pfValid(pfValid), .pfReady(pfReady), .pfAddr(pfAddr),
    .pfLatency(pfLatency), .strideValid(strideValid), .strideAddr(strideAddr),
    .strideCtx(strideCtx), .strideIsInst(strideIsInst), .ctxError(ctxError),
    .spanCount(spanCount), .issueCount(issueCount)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // Offer one access; on return the first falling edge after acceptance has passed.
  // Records candidates until the block is idle again.
  task automatic run_access(input logic [31:0] a, input bit inst, input logic [2:0] ctx,
                            input bit tagOn, output int issued, output bit sawStride,
                            output bit sawErr);
    int spanBefore;
    bit stop;
    spanBefore = expSpan;
    issued = 0;
    stop = 1'b0;
    @(negedge clk);
    accValid = 1'b1; accAddr = a; accIsInst = inst; accCtx = ctx;
    @(negedge clk);
    accValid = 1'b0;
    sawStride = strideValid;
    sawErr = ctxError;
    if (strideValid) begin
      check(strideAddr == a, "R7 stride address", strideAddr, a);
      check(strideCtx == ctx && strideIsInst == inst, "R7 stride ctx/flag",
            {strideCtx, strideIsInst}, {ctx, inst});
    end
    // bench model of the burst
    if (inst && tagOn && ctx < MAXC) begin
      for (int d = 1; d <= DEG; d++) begin
        logic [31:0] c;
        c = a + 32'(d * BLK);
        if (!stop && curStop && (c[31:12] != a[31:12])) begin
          stop = 1'b1;
          expSpan += DEG - d + 1;
        end
      end
    end
    for (int g = 0; g < 20; g++) begin
      if (accReady) break;
      if (pfValid) begin
        issued++;
        check(pfAddr == a + 32'(issued * BLK), "R2 candidate address", pfAddr,
              a + 32'(issued * BLK));
        check(int'(pfLatency) == curLat, "R5 latency tag", pfLatency, curLat);
        if (curStop)
          check(pfAddr[31:12] == a[31:12], "R3 candidate stays in page", pfAddr, a);
      end
      @(negedge clk);
    end
    expIssueTotal += issued;
    check(int'(spanCount) == expSpan, "R4 span counter", spanCount, expSpan);
    if (expSpan == spanBefore && curStop == 1'b0)
      check(int'(spanCount) == spanBefore, "R6 span unchanged", spanCount, spanBefore);
  endtask

  initial begin : watchdog
    #2000000;
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int iss;
    bit sv, se;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(pfValid == 0 && strideValid == 0 && ctxError == 0, "R1 outputs idle",
          {pfValid, strideValid, ctxError}, 0);
    check(accReady == 1, "R1 ready", accReady, 1);
    check(spanCount == 0 && issueCount == 0, "R1 counters", {spanCount, issueCount}, 0);
    check(int'(pfLatency) == LRST, "R1 latency default", pfLatency, LRST);
    rstN = 1'b1;

    // table walk with default config (tagging on, page stop on)
    for (int i = 0; i < 7; i++) begin
      run_access(VEC[i].addr, VEC[i].isInst, VEC[i].ctx, 1'b1, iss, sv, se);
      check(iss == int'(VEC[i].expIssued), "R2/R3 issued count", iss, VEC[i].expIssued);
      check(sv == VEC[i].expStride, "R7 stride pulse", sv, VEC[i].expStride);
      check(se == VEC[i].expErr, "R8 ctx error pulse", se, VEC[i].expErr);
    end

    // R8: bad-ctx pulse lasts one cycle
    @(negedge clk);
    check(ctxError == 0, "R8 error single cycle", ctxError, 0);

    // R9 backpressure: stall, busy access ignored
    @(negedge clk);
    pfReady = 1'b0;
    accValid = 1'b1; accAddr = 32'h0000_6000; accIsInst = 1'b1; accCtx = 3'd0;
    @(negedge clk);
    accAddr = 32'h0000_7777; accIsInst = 1'b0; accCtx = 3'd3;
    check(pfValid == 1 && pfAddr == 32'h6040, "R9 first candidate under stall", pfAddr, 32'h6040);
    check(accReady == 0, "R9 not ready while busy", accReady, 0);
    repeat (3) @(negedge clk);
    check(pfValid == 1 && pfAddr == 32'h6040, "R9 candidate held", pfAddr, 32'h6040);
    check(strideValid == 0, "R9 busy access not taken", strideValid, 0);
    accValid = 1'b0;
    pfReady = 1'b1;
    repeat (4) @(negedge clk);
    expIssueTotal += 4;
    check(accReady == 1, "R9 idle after burst", accReady, 1);
    check(strideValid == 0, "R9 no late forward", strideValid, 0);

    // R11 + R6: page stop off, new latency
    cfgWe = 1'b1; cfgInstTagged = 1'b1; cfgPageStop = 1'b0; cfgLatency = 8'd33;
    @(negedge clk);
    cfgWe = 1'b0;
    curStop = 1'b0; curLat = 33;
    check(pfLatency == 8'd33, "R11 latency loaded", pfLatency, 33);
    run_access(32'h0000_1FC0, 1'b1, 3'd0, 1'b1, iss, sv, se);
    check(iss == DEG, "R6 full burst across page", iss, DEG);
    check(sv == 0, "R7 burst not forwarded", sv, 0);

    // R11: tagging off -> instruction fetch forwarded
    @(negedge clk);
    cfgWe = 1'b1; cfgInstTagged = 1'b0;
    @(negedge clk);
    cfgWe = 1'b0;
    run_access(32'h0000_8000, 1'b1, 3'd4, 1'b0, iss, sv, se);
    check(iss == 0, "R11 no burst when tagging off", iss, 0);
    check(sv == 1, "R11 inst fetch forwarded when tagging off", sv, 1);

    // R10 issue counter
    @(negedge clk);
    check(int'(issueCount) == expIssueTotal, "R10 issue count", issueCount, expIssueTotal);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule